// File: doc/BRIEF.md
# DRAM Data Bus Turnaround Spacer

This block sits between the column-command scheduler of a DRAM controller and the DRAM command port. Each column command arrives with a direction (read or write), a rank select and a column address. The block passes the command through unchanged, but only once the shared data bus is free. That means the previous burst's data cycles have elapsed, plus any idle cycle that the transition into the new command requires. Until then it holds `in_ready` low, so the command waits upstream. Commands are never reordered or dropped.

Three turnaround options, each one bit, decide when an extra idle cycle is added:

- **Read then write:** always adds one cycle when enabled, whatever the ranks.
- **Write then read:** adds one cycle only when the read goes to a different rank.
- **Read then read:** adds one cycle only when the two reads go to different ranks.

A half-cycle CAS latency flag forces the read-then-write cycle whatever that option bit holds. A single write strobe loads all four configuration bits at once.

Top module: `ddr_turnaround_spacer`

## Requirements
- R1: After reset, `out_valid` is 0 with `in_valid` low, `in_ready` equals `out_ready`, and the first command accepted issues in the cycle it is presented, with no spacing penalty.
- R2: A command issues (`out_valid && out_ready`) in exactly the cycle it is accepted (`in_valid && in_ready`), with `out_is_wr`, `out_rank` and `out_addr` equal to the inputs. Commands leave in arrival order.
- R3: Two consecutive issues are at least BURST_CYC cycles apart (default 4). Write-to-write, and read-to-read on the same rank, are exactly BURST_CYC apart when presented back to back.
- R4: With the read-to-write bit set, a write following a read issues no earlier than BURST_CYC+1 cycles after it, for the same rank or a different one. With both the read-to-write bit and the half-cycle flag clear, the spacing is BURST_CYC.
- R5: With the half-cycle CAS flag set, a read-to-write transition gets BURST_CYC+1 spacing even when the read-to-write bit is 0.
- R6: The write-to-read bit resets to 1. When it is set, a read following a write to a different rank is spaced BURST_CYC+1. A same-rank write-then-read is spaced BURST_CYC. With the bit clear, the spacing is BURST_CYC.
- R7: With the read-to-read bit set, a read following a read to a different rank is spaced BURST_CYC+1. With the bit clear, or on the same rank, the spacing is BURST_CYC.
- R8: `in_ready` is never high while `out_ready` is low. A command presented during backpressure issues in the first cycle in which `out_ready` is high and its spacing has elapsed.
- R9: On a clock edge where `cfg_we` = 1, the block loads `cfg_r2w_idle`, `cfg_w2r_idle`, `cfg_r2r_idle` and `cfg_half_cas`. The new values govern commands accepted after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the four configuration bits |
| cfg_r2w_idle | input | 1 | Read-to-write extra cycle enable |
| cfg_w2r_idle | input | 1 | Write-to-read (rank change) extra cycle enable |
| cfg_r2r_idle | input | 1 | Read-to-read (rank change) extra cycle enable |
| cfg_half_cas | input | 1 | Half-cycle CAS latency flag; forces the read-to-write extra cycle |
| in_valid | input | 1 | Upstream command valid |
| in_ready | output | 1 | Command accepted this cycle when high together with `in_valid` |
| in_is_wr | input | 1 | Direction: 1 = write, 0 = read |
| in_rank | input | RANK_W | Rank select |
| in_addr | input | ADDR_W | Column address |
| out_valid | output | 1 | Command offered to the DRAM port |
| out_ready | input | 1 | DRAM port can take a command |
| out_is_wr | output | 1 | Direction of the issued command |
| out_rank | output | RANK_W | Rank of the issued command |
| out_addr | output | ADDR_W | Column address of the issued command |

## Verification
The bench sends back-to-back pairs that cover each kind of transition:

- write-write;
- read-read on one rank and on two ranks;
- read-write on one rank and on two ranks;
- write-read on one rank and on two ranks.

Each pair is run under three configurations: the reset setting, all options inverted, and the half-cycle CAS setting. A command that issues one cycle late or one cycle early shows which rule was wrongly applied or left out. Comparing same-rank and different-rank pairs shows whether the rank condition is honoured. Comparing the read-then-write spacing with the option bit set and with only the half-cycle flag set keeps the two causes apart. A command presented under `out_ready` backpressure that lasts longer than the spacing shows that the release cycle, and not the timer, decides when it issues.

// File: rtl/spacer_pkg.sv
package spacer_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } bus_dir_e;

  typedef struct packed {
    logic r2w;
    logic w2r;
    logic r2r;
    logic half_cas;
  } ta_cfg_t;

endpackage

// File: rtl/sp_cfg_regs.sv
module sp_cfg_regs
  import spacer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  ta_cfg_t wdata,
  output ta_cfg_t cfg
);

  ta_cfg_t cfg_d;
  ta_cfg_t cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.r2w      <= 1'b0;
      cfg_q.w2r      <= 1'b1;
      cfg_q.r2r      <= 1'b0;
      cfg_q.half_cas <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/sp_bus_history.sv
module sp_bus_history
  import spacer_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  bus_dir_e          cur_dir,
  input  logic [RANK_W-1:0] cur_rank,
  output logic              hist_valid,
  output bus_dir_e          prev_dir,
  output logic [RANK_W-1:0] prev_rank
);

  logic              valid_d, valid_q;
  bus_dir_e          dir_d, dir_q;
  logic [RANK_W-1:0] rank_d, rank_q;

  always_comb begin
    valid_d = valid_q;
    dir_d   = dir_q;
    rank_d  = rank_q;
    if (issue) begin
      valid_d = 1'b1;
      dir_d   = cur_dir;
      rank_d  = cur_rank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dir_q   <= DIR_RD;
      rank_q  <= '0;
    end else begin
      valid_q <= valid_d;
      dir_q   <= dir_d;
      rank_q  <= rank_d;
    end
  end

  assign hist_valid = valid_q;
  assign prev_dir   = dir_q;
  assign prev_rank  = rank_q;

endmodule

// File: rtl/sp_burst_timer.sv
module sp_burst_timer #(
  parameter int BURST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic base_ok,
  output logic extra_ok
);

  localparam int CNT_W = $clog2(BURST_CYC + 2);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BURST_CYC);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  // Loaded at issue; reads BURST_CYC+1-k in the k-th cycle after the issue.
  always_comb begin
    if (issue)              cnt_d = LOAD_VAL;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign base_ok  = (cnt_q <= CNT_W'(1));
  assign extra_ok = (cnt_q == '0);

endmodule

// File: rtl/sp_gap_rule.sv
module sp_gap_rule
  import spacer_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input  ta_cfg_t           cfg,
  input  logic              hist_valid,
  input  bus_dir_e          prev_dir,
  input  logic [RANK_W-1:0] prev_rank,
  input  bus_dir_e          cur_dir,
  input  logic [RANK_W-1:0] cur_rank,
  output logic              need_extra
);

  logic rank_change;
  logic rd_to_wr, wr_to_rd, rd_to_rd;

  always_comb begin
    rank_change = (prev_rank != cur_rank);
    rd_to_wr = (prev_dir == DIR_RD) && (cur_dir == DIR_WR);
    wr_to_rd = (prev_dir == DIR_WR) && (cur_dir == DIR_RD);
    rd_to_rd = (prev_dir == DIR_RD) && (cur_dir == DIR_RD);
    need_extra = 1'b0;
    if (hist_valid) begin
      if (rd_to_wr && (cfg.r2w || cfg.half_cas))  need_extra = 1'b1;
      if (wr_to_rd && rank_change && cfg.w2r)     need_extra = 1'b1;
      if (rd_to_rd && rank_change && cfg.r2r)     need_extra = 1'b1;
    end
  end

endmodule

// File: rtl/ddr_turnaround_spacer.sv
module ddr_turnaround_spacer
  import spacer_pkg::*;
#(
  parameter int BURST_CYC = 4,
  parameter int RANK_W    = 2,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_r2w_idle,
  input  logic              cfg_w2r_idle,
  input  logic              cfg_r2r_idle,
  input  logic              cfg_half_cas,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_wr,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_wr,
  output logic [RANK_W-1:0] out_rank,
  output logic [ADDR_W-1:0] out_addr
);

  ta_cfg_t           cfg_wdata, cfg;
  logic              hist_valid;
  bus_dir_e          prev_dir, cur_dir;
  logic [RANK_W-1:0] prev_rank;
  logic              need_extra, base_ok, extra_ok, gap_ok, issue;

  assign cfg_wdata = '{r2w: cfg_r2w_idle, w2r: cfg_w2r_idle,
                       r2r: cfg_r2r_idle, half_cas: cfg_half_cas};
  assign cur_dir   = bus_dir_e'(in_is_wr);

  sp_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  sp_bus_history #(.RANK_W(RANK_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .cur_dir(cur_dir), .cur_rank(in_rank),
    .hist_valid(hist_valid), .prev_dir(prev_dir), .prev_rank(prev_rank)
  );

  sp_gap_rule #(.RANK_W(RANK_W)) u_rule (
    .cfg(cfg), .hist_valid(hist_valid),
    .prev_dir(prev_dir), .prev_rank(prev_rank),
    .cur_dir(cur_dir), .cur_rank(in_rank),
    .need_extra(need_extra)
  );

  sp_burst_timer #(.BURST_CYC(BURST_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .base_ok(base_ok), .extra_ok(extra_ok)
  );

  assign gap_ok    = need_extra ? extra_ok : base_ok;
  assign in_ready  = out_ready && gap_ok;
  assign out_valid = in_valid && gap_ok;
  assign issue     = in_valid && in_ready;
  assign out_is_wr = in_is_wr;
  assign out_rank  = in_rank;
  assign out_addr  = in_addr;

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int BURST_CYC = 4,
  parameter int RANK_W    = 2,
  parameter int ADDR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_r2w_idle,
  input logic              cfg_w2r_idle,
  input logic              cfg_r2r_idle,
  input logic              cfg_half_cas,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_wr,
  input logic [RANK_W-1:0] in_rank,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_wr,
  input logic [RANK_W-1:0] out_rank,
  input logic [ADDR_W-1:0] out_addr
);

  localparam int SW = $clog2(BURST_CYC + 3);
  localparam logic [SW-1:0] LIM = SW'(BURST_CYC + 1);

  logic              acc, seen, p_wr;
  logic [RANK_W-1:0] p_rank;
  logic [SW-1:0]     since;
  logic              m_r2w, m_w2r, m_r2r, m_half;
  logic              spaced_base, spaced_extra, rank_chg;

  assign acc          = in_valid && in_ready;
  assign spaced_base  = (int'(since) >= BURST_CYC);
  assign spaced_extra = (int'(since) >= BURST_CYC + 1);
  assign rank_chg     = (p_rank != in_rank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; p_wr <= 1'b0; p_rank <= '0; since <= '0;
      m_r2w <= 1'b0; m_w2r <= 1'b1; m_r2r <= 1'b0; m_half <= 1'b0;
    end else begin
      if (acc) begin
        seen <= 1'b1; p_wr <= in_is_wr; p_rank <= in_rank; since <= SW'(1);
      end else if (since < LIM) begin
        since <= since + 1'b1;
      end
      if (cfg_we) begin
        m_r2w <= cfg_r2w_idle; m_w2r <= cfg_w2r_idle;
        m_r2r <= cfg_r2r_idle; m_half <= cfg_half_cas;
      end
    end
  end

  assert_first_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && out_ready) |-> in_ready);

  assert_issue_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (acc && out_is_wr == in_is_wr &&
                                  out_rank == in_rank && out_addr == in_addr));

  assert_accept_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (out_valid && out_ready));

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen) |-> spaced_base);

  assert_r2w_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && !p_wr && in_is_wr && m_r2w) |-> spaced_extra);

  assert_half_cas_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && !p_wr && in_is_wr && m_half) |-> spaced_extra);

  assert_w2r_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && p_wr && !in_is_wr && rank_chg && m_w2r) |-> spaced_extra);

  assert_r2r_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && !p_wr && !in_is_wr && rank_chg && m_r2r) |-> spaced_extra);

  assert_ready_needs_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

endmodule

bind ddr_turnaround_spacer sp_checker #(
  .BURST_CYC(BURST_CYC), .RANK_W(RANK_W), .ADDR_W(ADDR_W)
) u_sp_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .cfg_r2w_idle(cfg_r2w_idle), .cfg_w2r_idle(cfg_w2r_idle),
  .cfg_r2r_idle(cfg_r2r_idle), .cfg_half_cas(cfg_half_cas),
  .in_valid(in_valid), .in_ready(in_ready), .in_is_wr(in_is_wr),
  .in_rank(in_rank), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_is_wr(out_is_wr),
  .out_rank(out_rank), .out_addr(out_addr)
);

// File: tb/tb_ddr_turnaround_spacer.sv
`timescale 1ns/1ps
module tb_ddr_turnaround_spacer;

  localparam int BL = 4;
  localparam int RW = 2;
  localparam int AW = 16;

  typedef struct {
    logic          wr;
    logic [RW-1:0] rank;
    logic [AW-1:0] addr;
    int            cyc;
    string         tag;
  } exp_t;

  logic clk, rst_n;
  logic cfg_we, cfg_r2w_idle, cfg_w2r_idle, cfg_r2r_idle, cfg_half_cas;
  logic in_valid, in_ready, in_is_wr, out_valid, out_ready, out_is_wr;
  logic [RW-1:0] in_rank, out_rank;
  logic [AW-1:0] in_addr, out_addr;

  int cyc, n_checks, n_fail;
  int last_cyc;
  bit have_last, last_wr, done;
  logic [RW-1:0] last_rank;
  bit m_r2w, m_w2r, m_r2r, m_half;
  exp_t sb[$];

  ddr_turnaround_spacer #(.BURST_CYC(BL), .RANK_W(RW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_r2w_idle(cfg_r2w_idle), .cfg_w2r_idle(cfg_w2r_idle),
    .cfg_r2r_idle(cfg_r2r_idle), .cfg_half_cas(cfg_half_cas),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_wr(in_is_wr),
    .in_rank(in_rank), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_wr(out_is_wr),
    .out_rank(out_rank), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Spacing rules taken from R3..R7.
  function automatic int gap_for(input bit wr, input logic [RW-1:0] rank);
    bit chg;
    chg = (rank != last_rank);
    if (!last_wr && wr && (m_r2w || m_half)) return BL + 1;
    if (last_wr && !wr && chg && m_w2r)      return BL + 1;
    if (!last_wr && !wr && chg && m_r2r)     return BL + 1;
    return BL;
  endfunction

  // Driver: called at a negedge, returns at the negedge after acceptance.
  task automatic send(input bit wr, input int rank, input int addr,
                      input int hold, input string tag);
    exp_t e;
    int tp, ex;
    in_valid = 1'b1;
    in_is_wr = wr;
    in_rank  = RW'(rank);
    in_addr  = AW'(addr);
    out_ready = (hold == 0);
    tp = cyc;
    ex = tp + hold;
    if (have_last && (last_cyc + gap_for(wr, RW'(rank)) > ex))
      ex = last_cyc + gap_for(wr, RW'(rank));
    e.wr = wr; e.rank = RW'(rank); e.addr = AW'(addr); e.cyc = ex; e.tag = tag;
    sb.push_back(e);
    if (hold > 0) begin
      #1;
      check(in_ready == 1'b0, "R8", "in_ready under backpressure", in_ready, 0);
      repeat (hold) @(negedge clk);
      out_ready = 1'b1;
    end
    #1;
    while (!in_ready && !done) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    have_last = 1'b1;
    last_cyc  = ex;
    last_wr   = wr;
    last_rank = RW'(rank);
    @(negedge clk);
  endtask

  task automatic write_cfg(input bit r2w, input bit w2r, input bit r2r, input bit half);
    in_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_r2w_idle = r2w; cfg_w2r_idle = w2r; cfg_r2r_idle = r2r; cfg_half_cas = half;
    @(posedge clk);
    m_r2w = r2w; m_w2r = w2r; m_r2r = r2r; m_half = half;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every issued command.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected issue", out_addr, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_is_wr == e.wr && out_rank == e.rank && out_addr == e.addr,
              e.tag, "issued command fields (addr)", out_addr, e.addr);
        check(cyc == e.cyc, e.tag, "issue cycle", cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cyc = 0; n_checks = 0; n_fail = 0; done = 1'b0;
    have_last = 1'b0; last_wr = 1'b0; last_rank = '0; last_cyc = 0;
    m_r2w = 1'b0; m_w2r = 1'b1; m_r2r = 1'b0; m_half = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0;
    cfg_r2w_idle = 1'b0; cfg_w2r_idle = 1'b0; cfg_r2r_idle = 1'b0; cfg_half_cas = 1'b0;
    in_valid = 1'b0; in_is_wr = 1'b0; in_rank = '0; in_addr = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    send(0, 0, 16'h0100, 0, "R1");   // first command: no penalty
    send(0, 0, 16'h0101, 0, "R3");   // rd->rd same rank
    send(1, 0, 16'h0102, 0, "R4");   // rd->wr, option off
    send(1, 0, 16'h0103, 0, "R3");   // wr->wr
    send(0, 0, 16'h0104, 0, "R6");   // wr->rd same rank: no extra
    send(1, 1, 16'h0105, 0, "R4");   // rd->wr other rank, option off
    send(0, 2, 16'h0106, 0, "R6");   // wr->rd rank change, reset value 1
    send(0, 3, 16'h0107, 0, "R7");   // rd->rd rank change, option off

    write_cfg(1, 0, 1, 0);
    send(0, 3, 16'h0200, 0, "R9");   // rd->rd same rank after new config
    send(1, 3, 16'h0201, 0, "R4");   // rd->wr same rank, option on
    send(0, 0, 16'h0202, 0, "R6");   // wr->rd rank change, option off
    send(1, 1, 16'h0203, 0, "R4");   // rd->wr other rank, option on
    send(0, 1, 16'h0204, 0, "R9");
    send(0, 2, 16'h0205, 0, "R7");   // rd->rd rank change, option on
    send(0, 2, 16'h0206, 0, "R7");   // rd->rd same rank

    write_cfg(0, 1, 0, 1);
    send(1, 2, 16'h0300, 0, "R5");   // rd->wr forced by half-cycle CAS
    send(1, 2, 16'h0301, 0, "R3");
    send(0, 2, 16'h0302, 7, "R8");   // backpressure longer than spacing
    send(1, 0, 16'h0303, 1, "R5");   // short backpressure, spacing dominates

    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "pending expected commands", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule